// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Node

This block is the serial control section of one node in a square array of switch nodes. All nodes share one programming path. A bit-serial 30-bit control word arrives on `serIn`, most significant bit first, and is sampled on the rising edge of `sclk`. Every word is passed on to the right-hand neighbour over `rowData`/`rowClk` and to the lower neighbour over `colData`/`colClk`. Nodes are addressed by relative position rather than by a fixed identity. A word leaving towards the right has its column field reduced by one, and a word leaving downward has its row field reduced by one. The node that receives a word with both fields at zero is its target.

A write word that targets the node is stored in a staging (load) register. A high `loadStrobe` copies the staged select codes into the live configuration. The four 3-bit select codes drive the switch fabric through `selOut`. A read word that targets the node leaves with the node's live select codes in place of its payload. Because of the per-hop decrement, the address field of that word reads all ones when it leaves, and it drops by one at each node it passes afterwards. A receiver at the edge of the array can therefore work out how far away the source is. After the read word has passed, the node accepts write words again with no further action.

Top module: `chain_cfg_node`

## Requirements
- R1: While `rstN` is low, `selOut` is all zero, both data outputs are low and both forwarded clocks are held low.
- R2: A bit sampled on `serIn` at rising edge k that is not part of a recognised word appears unchanged on both `rowData` and `colData` after the falling edge that follows rising edge k+6, so a neighbour samples it on its 7th rising edge.
- R3: A word is recognised when its first six bits, taken MSB first, are 011111 (write) or 011110 (read). The word layout is: bits 29:24 frame code, 23:18 row field, 17:12 column field, then the select fields for outputs 1, 2, 3 and 4 in bits 11:9, 8:6, 5:3 and 2:0. While a word is in flight, no new word can start before that word's last bit. A word may follow the last bit of the previous word with no gap.
- R4: On `colData`, the row field of every recognised word is one less than it was on arrival, modulo 64. All other bits are unchanged unless R9 applies.
- R5: On `rowData`, the column field of every recognised word is one less than it was on arrival, modulo 64. All other bits are unchanged unless R9 applies.
- R6: A write word that arrives with row and column fields both zero is placed in the load register on the second rising edge after its last bit. A `loadStrobe` sampled on that same edge still transfers the old contents. Write words with any other address are never stored.
- R7: When `loadStrobe` is high at a rising edge, each staged select code in the range 000 to 100 is copied to its `selOut` field on that edge. Code 000 means the output is disconnected, and codes 001 to 100 pick inputs 1 to 4. Without the strobe, `selOut` does not change.
- R8: A staged select code of 101, 110 or 111 is ignored when the strobe is applied. Its field keeps its previous value, and valid codes in the other fields are still copied.
- R9: A read word that arrives with row and column fields both zero leaves on both outputs with bits 11:0 replaced by the current `selOut`, with output 1 at bits 11:9. Its outgoing address field therefore reads 111111.
- R10: A read word with any other address is forwarded with its payload untouched. A write word that arrives after it is handled normally.
- R11: After reset, `rowClk` and `colClk` follow `sclk`. Data outputs change only on falling edges of `sclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial control data, sampled on the rising edge |
| loadStrobe | input | 1 | Copies the staged codes into the live configuration |
| rowData | output | 1 | Data forwarded to the right-hand neighbour |
| rowClk | output | 1 | Clock forwarded to the right-hand neighbour |
| colData | output | 1 | Data forwarded to the lower neighbour |
| colClk | output | 1 | Clock forwarded to the lower neighbour |
| selOut | output | 12 | Live select codes, output 1 in bits 11:9 down to output 4 in bits 2:0 |

## Verification
The bench uses the default package values: 6-bit frame and address fields, four 3-bit select fields, and a 7-stage lookahead window. With a 6-bit field, the wrap from 000000 to 111111 occurs on every targeted word, so the borrow is checked across its full length. Four fields of three bits leave codes 101 to 111 free, so invalid codes can be mixed with valid ones inside one word. A 12-bit payload can hold a fake frame code, which exercises the in-flight lockout and the back-to-back start.

// File: rtl/chain_cfg_pkg.sv
package chain_cfg_pkg;
  parameter int FRAME_W = 6;
  parameter int ADDR_W  = 6;
  parameter int SEL_W   = 3;
  parameter int NUM_SEL = 4;
  parameter logic [FRAME_W-1:0] WR_CODE = 6'b011111;
  parameter logic [FRAME_W-1:0] RD_CODE = 6'b011110;

  localparam int PAY_W    = NUM_SEL * SEL_W;
  localparam int WORD_W   = FRAME_W + 2 * ADDR_W + PAY_W;
  localparam int DLY      = ADDR_W + 1;
  localparam int SR_LEN   = (PAY_W > DLY) ? PAY_W : DLY;
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int POS_W    = $clog2(ADDR_W);
  localparam int PIDX_W   = $clog2(PAY_W);
  localparam int ROW_LO   = FRAME_W;
  localparam int COL_LO   = FRAME_W + ADDR_W;
  localparam int PAY_LO   = FRAME_W + 2 * ADDR_W;
  localparam int CAP_IDX  = WORD_W - DLY;
  localparam int MAX_CODE = NUM_SEL;

  typedef struct packed {
    logic              rowPhase;
    logic              colPhase;
    logic [POS_W-1:0]  fieldPos;
    logic              insert;
    logic [PIDX_W-1:0] payIdx;
    logic              capture;
  } node_strobe_t;
endpackage

// File: rtl/chain_cfg_ctrl.sv
module chain_cfg_ctrl
  import chain_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [FRAME_W-1:0] frameWin,
  input  logic               tapBit,
  output node_strobe_t       strobe
);
  localparam logic [IDX_W-1:0] ROW_LO_I  = IDX_W'(ROW_LO);
  localparam logic [IDX_W-1:0] COL_LO_I  = IDX_W'(COL_LO);
  localparam logic [IDX_W-1:0] PAY_LO_I  = IDX_W'(PAY_LO);
  localparam logic [IDX_W-1:0] LAST_I    = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] CAP_I     = IDX_W'(CAP_IDX);

  logic             active;
  logic [IDX_W-1:0] bitIdx;   // word position of the bit now at the tap
  logic             isRead;
  logic             addrZero;
  logic             codeSeen;
  logic             frameHit;
  logic             inRow;
  logic             inCol;
  logic             inPay;

  assign codeSeen = (frameWin == WR_CODE) || (frameWin == RD_CODE);
  // a new word may only start when idle or right behind the last bit
  assign frameHit = codeSeen && (!active || bitIdx == LAST_I);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      bitIdx   <= '0;
      isRead   <= 1'b0;
      addrZero <= 1'b0;
    end else if (frameHit) begin
      active   <= 1'b1;
      bitIdx   <= '0;
      isRead   <= (frameWin == RD_CODE);
      addrZero <= 1'b1;
    end else if (active) begin
      if (bitIdx == LAST_I) active <= 1'b0;
      else                  bitIdx <= bitIdx + IDX_W'(1);
      if (bitIdx >= ROW_LO_I && bitIdx < PAY_LO_I) addrZero <= addrZero & ~tapBit;
    end
  end

  assign inRow = active && bitIdx >= ROW_LO_I && bitIdx < COL_LO_I;
  assign inCol = active && bitIdx >= COL_LO_I && bitIdx < PAY_LO_I;
  assign inPay = active && bitIdx >= PAY_LO_I;

  always_comb begin
    strobe.rowPhase = inRow;
    strobe.colPhase = inCol;
    strobe.fieldPos = inRow ? POS_W'(bitIdx - ROW_LO_I) : POS_W'(bitIdx - COL_LO_I);
    strobe.insert   = inPay && isRead && addrZero;
    strobe.payIdx   = PIDX_W'(bitIdx - PAY_LO_I);
    strobe.capture  = active && !isRead && addrZero && bitIdx == CAP_I;
  end
endmodule

// File: rtl/chain_cfg_dp.sv
module chain_cfg_dp
  import chain_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               serIn,
  input  logic               loadStrobe,
  input  node_strobe_t       strobe,
  output logic [FRAME_W-1:0] frameWin,
  output logic               tapBit,
  output logic               rowData,
  output logic               colData,
  output logic [PAY_W-1:0]   loadRegQ,
  output logic [PAY_W-1:0]   selQ
);
  logic [SR_LEN-1:0] shiftQ;
  logic [ADDR_W-2:0] lowWin;
  logic [ADDR_W-2:0] lowMask;
  logic              borrowFlip;
  logic              cfgBit;
  logic              rowNext;
  logic              colNext;
  logic              capValid;
  logic [PAY_W-1:0]  capData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[SR_LEN-2:0], serIn};
  end

  assign tapBit   = shiftQ[DLY-1];
  assign frameWin = shiftQ[DLY-2 -: FRAME_W];
  assign lowWin   = shiftQ[DLY-2:1];

  // a field bit flips on decrement when every less significant bit of the field is zero
  assign lowMask    = {(ADDR_W-1){1'b1}} << strobe.fieldPos;
  assign borrowFlip = (lowWin & lowMask) == '0;
  assign cfgBit     = selQ[PIDX_W'(PAY_W - 1) - strobe.payIdx];

  always_comb begin
    rowNext = tapBit;
    colNext = tapBit;
    if (strobe.colPhase) rowNext = tapBit ^ borrowFlip;
    if (strobe.rowPhase) colNext = tapBit ^ borrowFlip;
    if (strobe.insert) begin
      rowNext = cfgBit;
      colNext = cfgBit;
    end
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rowData <= 1'b0;
      colData <= 1'b0;
    end else begin
      rowData <= rowNext;
      colData <= colNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capData  <= '0;
      loadRegQ <= '0;
    end else begin
      capValid <= strobe.capture;
      if (strobe.capture) capData <= shiftQ[PAY_W-1:0];
      if (capValid) loadRegQ <= capData;
    end
  end

  for (genvar f = 0; f < NUM_SEL; f++) begin : g_sel
    localparam int HI = PAY_W - 1 - f * SEL_W;
    logic [SEL_W-1:0] fieldQ;
    logic [SEL_W-1:0] staged;
    assign staged = loadRegQ[HI -: SEL_W];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) fieldQ <= '0;
      else if (loadStrobe && staged <= SEL_W'(MAX_CODE)) fieldQ <= staged;
    end
    assign selQ[HI -: SEL_W] = fieldQ;
  end
endmodule

// File: rtl/chain_cfg_node.sv
module chain_cfg_node
  import chain_cfg_pkg::*;
(
  input  logic             sclk,
  input  logic             rstN,
  input  logic             serIn,
  input  logic             loadStrobe,
  output logic             rowData,
  output logic             rowClk,
  output logic             colData,
  output logic             colClk,
  output logic [PAY_W-1:0] selOut
);
  node_strobe_t       strobe;
  logic [FRAME_W-1:0] frameWin;
  logic               tapBit;
  logic [PAY_W-1:0]   loadRegQ;
  logic               clkEn;

  chain_cfg_ctrl u_ctrl (
    .clk      (sclk),
    .rstN     (rstN),
    .frameWin (frameWin),
    .tapBit   (tapBit),
    .strobe   (strobe)
  );

  chain_cfg_dp u_dp (
    .clk        (sclk),
    .rstN       (rstN),
    .serIn      (serIn),
    .loadStrobe (loadStrobe),
    .strobe     (strobe),
    .frameWin   (frameWin),
    .tapBit     (tapBit),
    .rowData    (rowData),
    .colData    (colData),
    .loadRegQ   (loadRegQ),
    .selQ       (selOut)
  );

  // enable changes while the clock is low, so the gated copies never glitch
  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN) clkEn <= 1'b0;
    else       clkEn <= 1'b1;
  end

  assign rowClk = sclk & clkEn;
  assign colClk = sclk & clkEn;
endmodule

// File: rtl/chain_cfg_checker.sv
module chain_cfg_checker
  import chain_cfg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             loadStrobe,
  input logic [PAY_W-1:0] loadReg,
  input logic [PAY_W-1:0] selOut
);
  assert_hold_no_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |=> $stable(selOut));

  for (genvar f = 0; f < NUM_SEL; f++) begin : g_chk
    localparam int HI = PAY_W - 1 - f * SEL_W;

    assert_sel_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
      selOut[HI -: SEL_W] <= SEL_W'(MAX_CODE));

    assert_invalid_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
      (loadStrobe && loadReg[HI -: SEL_W] > SEL_W'(MAX_CODE)) |=> $stable(selOut[HI -: SEL_W]));

    assert_load_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
      (loadStrobe && loadReg[HI -: SEL_W] <= SEL_W'(MAX_CODE))
        |=> selOut[HI -: SEL_W] == $past(loadReg[HI -: SEL_W]));
  end
endmodule

bind chain_cfg_node chain_cfg_checker u_chk (
  .clk        (sclk),
  .rstN       (rstN),
  .loadStrobe (loadStrobe),
  .loadReg    (loadRegQ),
  .selOut     (selOut)
);

// File: tb/chain_cfg_node_tb.sv
`timescale 1ns/1ps
module chain_cfg_node_tb;
  localparam int LAT = 7;
  localparam logic [5:0] WR = 6'b011111;
  localparam logic [5:0] RD = 6'b011110;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serIn = 1'b0;
  logic        loadStrobe = 1'b0;
  logic        rowData, rowClk, colData, colClk;
  logic [11:0] selOut;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  bit    expRowQ[$];
  bit    expColQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  chain_cfg_node u_dut (
    .sclk(clk), .rstN(rstN), .serIn(serIn), .loadStrobe(loadStrobe),
    .rowData(rowData), .rowClk(rowClk), .colData(colData), .colClk(colClk),
    .selOut(selOut)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected bit per cycle once the pipeline is full
  always @(posedge clk) begin
    #5;
    if (rstN && expRowQ.size() > LAT) begin
      automatic bit er = expRowQ.pop_front();
      automatic bit ec = expColQ.pop_front();
      automatic string t = tagQ.pop_front();
      check({t, " rowData"}, {11'd0, rowData}, {11'd0, er});
      check({t, " colData"}, {11'd0, colData}, {11'd0, ec});
    end
  end

  task automatic sendBit(input bit b, input bit ld, input bit er, input bit ec, input string tag);
    @(negedge clk);
    serIn = b;
    loadStrobe = ld;
    expRowQ.push_back(er);
    expColQ.push_back(ec);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) sendBit(1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  function automatic logic [29:0] mkWord(input logic [5:0] code, input logic [5:0] row,
                                         input logic [5:0] col, input logic [11:0] pay);
    return {code, row, col, pay};
  endfunction

  function automatic logic [29:0] fwd(input logic [29:0] w, input bit toRow, input logic [11:0] cfg);
    logic [29:0] r = w;
    if (toRow) r[17:12] = w[17:12] - 6'd1;
    else       r[23:18] = w[23:18] - 6'd1;
    if (w[29:24] == RD && w[23:18] == 6'd0 && w[17:12] == 6'd0) r[11:0] = cfg;
    return r;
  endfunction

  task automatic sendWord(input logic [29:0] w, input logic [11:0] cfg, input string tag);
    logic [29:0] rw = fwd(w, 1'b1, cfg);
    logic [29:0] cw = fwd(w, 1'b0, cfg);
    for (int i = 29; i >= 0; i--) sendBit(w[i], 1'b0, rw[i], cw[i], tag);
  endtask

  task automatic checkSel(input logic [11:0] exp, input string tag);
    @(posedge clk);
    #5;
    check({tag, " selOut"}, selOut, exp);
  endtask

  // strobe on the third rising edge after the last word bit
  task automatic loadLate(input logic [11:0] exp, input string tag);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0, tag);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0, tag);
    sendBit(1'b0, 1'b1, 1'b0, 1'b0, tag);
    checkSel(exp, tag);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat = 16'hA5A5;
    repeat (3) @(posedge clk);
    #5;
    check("R1 selOut", selOut, 12'h000);
    check("R1 rowData/colData", {10'd0, rowData, colData}, 12'd0);
    check("R1 R11 clocks held low", {10'd0, rowClk, colClk}, 12'd0);
    rstN = 1'b1;

    idle(4, "R2 idle");
    @(posedge clk);
    #5;
    check("R11 forwarded clocks high", {10'd0, rowClk, colClk}, 12'd3);

    // raw traffic with no frame code in any window passes untouched
    for (int i = 15; i >= 0; i--) sendBit(pat[i], 1'b0, pat[i], pat[i], "R2 passthrough");
    idle(8, "R2 idle");

    // targeted write, strobe too early then on time
    sendWord(mkWord(WR, 6'd0, 6'd0, {3'd1, 3'd2, 3'd3, 3'd4}), 12'h0, "R4 R5 R6 write00");
    sendBit(1'b0, 1'b0, 1'b0, 1'b0, "R6");
    sendBit(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    checkSel(12'h000, "R6 strobe on second edge keeps old");
    sendBit(1'b0, 1'b1, 1'b0, 1'b0, "R6");
    checkSel({3'd1, 3'd2, 3'd3, 3'd4}, "R7 strobe on third edge");
    idle(5, "R7 idle");
    checkSel({3'd1, 3'd2, 3'd3, 3'd4}, "R7 no strobe no change");

    // write for another node is not stored
    sendWord(mkWord(WR, 6'd2, 6'd3, {3'd2, 3'd2, 3'd2, 3'd2}), 12'h0, "R4 R5 write23");
    loadLate({3'd1, 3'd2, 3'd3, 3'd4}, "R6 foreign write not stored");
    idle(3, "R6 idle");

    // fake frame code in payload, then a back-to-back targeted write with invalid codes
    sendWord(mkWord(WR, 6'd1, 6'd2, 12'b011111_011110), 12'h0, "R3 lockout");
    sendWord(mkWord(WR, 6'd0, 6'd0, {3'd5, 3'd1, 3'd7, 3'd2}), 12'h0, "R3 back-to-back");
    loadLate({3'd1, 3'd1, 3'd3, 3'd2}, "R8 invalid codes kept");
    idle(3, "R8 idle");

    // targeted read carries live configuration
    sendWord(mkWord(RD, 6'd0, 6'd0, 12'hFFF), {3'd1, 3'd1, 3'd3, 3'd2}, "R9 read00");
    idle(4, "R9 idle");

    // foreign read untouched, then write handled normally
    sendWord(mkWord(RD, 6'd0, 6'd2, 12'h5A3), 12'h0, "R10 read02");
    sendWord(mkWord(WR, 6'd0, 6'd0, {3'd0, 3'd4, 3'd4, 3'd0}), 12'h0, "R10 write after read");
    loadLate({3'd0, 3'd4, 3'd4, 3'd0}, "R10 R7 write after read loaded");
    idle(2, "R10 idle");
    sendWord(mkWord(RD, 6'd0, 6'd0, 12'h000), {3'd0, 3'd4, 3'd4, 3'd0}, "R9 read00 again");

    idle(LAT + 4, "R2 flush");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule